// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block sits between on-chip logic and an external three-wire serial EEPROM. A client hands it one command at a time over a valid/ready request port: the command code, a cell address, write data, and whether the memory is organised as 16-bit or 8-bit words. The controller builds the serial frame for that command and drives chip select, serial clock and serial data out. It samples the memory's data line and returns one response per command, with read data and a timeout flag.

All serial timing is counted in system clock cycles and set by parameters: each clock half-period, the minimum chip-select low time between frames, and the status settle time. The frame length follows the organisation width. In 8-bit mode the address has one more bit, and data fields are 8 bits instead of 16. Commands that start a self-timed program or erase are followed by a status poll. The controller drops chip select, raises it again, waits for the status to settle, and then watches the data line until the memory reports ready or a per-command limit runs out.

Top module: `mw_eeprom_host`

## Requirements
- R1: During and straight after reset, `mw_cs`, `mw_sk`, `mw_di` and `rsp_valid` are low and `req_ready` is high.
- R2: A frame is sent MSB first on `mw_di` as follows. It starts with a 1. Next comes a 2-bit code: read 10, write 01, erase 11, and 00 for the four whole-array/enable commands. Then come the address bits, ADDR_W bits when `req_x16`=1 and ADDR_W+1 bits when it is 0. For the 00 commands, the address field's top two bits are a sub-code and the rest are 0: enable 11, disable 00, erase-all 10, write-all 01. Write and write-all then append 16 or 8 data bits. `req_cmd` encodes read=0, write=1, erase=2, enable=3, disable=4, erase-all=5, write-all=6, and 7 behaves as disable. `mw_di` is 0 once the frame's bits are used up.
- R3: A frame has 3+A rising `mw_sk` edges, where A is the address width. Read, write and write-all add D more edges, where D is 16 or 8.
- R4: Every `mw_sk` high and low phase lasts exactly HALF_CYC cycles. `mw_di` changes only in the cycle in which `mw_sk` falls, or while `mw_sk` is low.
- R5: `mw_cs` rises HALF_CYC cycles before the first rising `mw_sk` edge, and `mw_sk` is low whenever `mw_cs` is low.
- R6: Every frame ends one low phase after its last pulse. `mw_cs` then stays low for at least CS_LOW_CYC cycles before it rises again.
- R7: For a read, `mw_do` is sampled at the end of the low phase after each data pulse. The dummy bit output during the last address pulse is not captured. Data is right-aligned in `rsp_rdata` with the upper bits zero in 8-bit mode, and `rsp_rdata` is zero for every other command.
- R8: After a write, erase, erase-all or write-all frame, `mw_cs` stays low for CS_LOW_CYC cycles, then high for STAT_CYC cycles. After that `mw_do` is checked every cycle, and a high level ends the command with `rsp_valid` and `rsp_timeout`=0.
- R9: The poll limit is counted from the cycle in which the frame ended: TO_ONE_CYC for write and erase, TO_ERASE_ALL_CYC for erase-all, TO_WRITE_ALL_CYC for write-all. If `mw_do` is still low after the limit, the command ends with `rsp_timeout`=1. A high `mw_do` takes precedence.
- R10: Read, enable and disable do not poll. `rsp_valid` is raised in the cycle after the frame's last low phase ends.
- R11: `rsp_valid` is a one-cycle pulse. `req_ready` is low from acceptance until CS_LOW_CYC cycles after the response, so the next frame sees the minimum chip-select low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_cmd | input | 3 | Command code (R2 encoding) |
| req_addr | input | ADDR_W+1 | Cell address; top bit used only in 8-bit mode |
| req_wdata | input | 16 | Write data; low 8 bits in 8-bit mode |
| req_x16 | input | 1 | 1 = 16-bit organisation, 0 = 8-bit |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result |
| rsp_timeout | output | 1 | Status poll expired (valid with rsp_valid) |
| mw_cs | output | 1 | Serial chip select |
| mw_sk | output | 1 | Serial clock |
| mw_di | output | 1 | Serial data to the memory |
| mw_do | input | 1 | Serial data / ready status from the memory |

## Verification
The embedded properties assume that `req_cmd`, `req_addr`, `req_wdata` and `req_x16` are held while `req_valid` is high and are only sampled at acceptance. They also assume that `mw_do` has no effect on the serial outputs except through the read capture and the poll decision. The bench drives every request field in the cycle before acceptance and releases `req_valid` straight after. It plays the memory's data line from its own per-cycle schedule: a high idle level, a 0 dummy bit, data bits after each rising edge, and busy-then-ready or never-ready levels after a program frame. The poll timing and the timeout outcome therefore follow from the stimulus alone.

// File: rtl/mw_host_pkg.sv
package mw_host_pkg;

   typedef enum logic [2:0] {
      CMD_READ       = 3'd0,
      CMD_WRITE      = 3'd1,
      CMD_ERASE      = 3'd2,
      CMD_ENABLE     = 3'd3,
      CMD_DISABLE    = 3'd4,
      CMD_ERASE_ALL  = 3'd5,
      CMD_WRITE_ALL  = 3'd6,
      CMD_RSVD       = 3'd7
   } mw_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_REST,
      ST_STAT,
      ST_POLL,
      ST_GAP
   } mw_state_e;

   localparam logic [1:0] LIM_ONE       = 2'd0;
   localparam logic [1:0] LIM_ERASE_ALL = 2'd1;
   localparam logic [1:0] LIM_WRITE_ALL = 2'd2;

endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
   parameter int unsigned HALF_CYC = 63
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(HALF_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   generate
      if (HALF_CYC > 1) begin : g_multi
         // R4
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
   parameter int unsigned TO_ONE_CYC       = 2500000,
   parameter int unsigned TO_ERASE_ALL_CYC = 3750000,
   parameter int unsigned TO_WRITE_ALL_CYC = 7500000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       expired
);
   import mw_host_pkg::*;

   localparam int unsigned M1   = (TO_ONE_CYC > TO_ERASE_ALL_CYC) ? TO_ONE_CYC : TO_ERASE_ALL_CYC;
   localparam int unsigned TMAX = (M1 > TO_WRITE_ALL_CYC) ? M1 : TO_WRITE_ALL_CYC;
   localparam int unsigned TW   = $clog2(TMAX + 2);

   logic [TW-1:0] cnt;
   logic [TW-1:0] limit;

   always_comb begin
      case (sel)
         LIM_ERASE_ALL: limit = TW'(TO_ERASE_ALL_CYC);
         LIM_WRITE_ALL: limit = TW'(TO_WRITE_ALL_CYC);
         default:       limit = TW'(TO_ONE_CYC);
      endcase
   end

   assign expired = (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (run && !expired) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9
   timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear && expired) |=> expired);

endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
   import mw_host_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned FW     = ADDR_W + 20,
   parameter int unsigned LW     = 5
) (
   input  mw_cmd_e           cmd,
   input  logic [ADDR_W:0]   addr,
   input  logic [15:0]       wdata,
   input  logic              x16,
   output logic [FW-1:0]     frame,
   output logic [LW-1:0]     n_cmd,
   output logic [LW-1:0]     n_total,
   output logic              is_read,
   output logic              is_prog,
   output logic [1:0]        lim_sel
);
   always_comb begin
      int unsigned aw;
      int unsigned dw;
      int unsigned len;
      logic [FW-1:0] v;
      logic [FW-1:0] af;
      logic [1:0]    opb;
      logic [1:0]    sub;
      logic          spec;
      logic          hasd;

      aw      = x16 ? ADDR_W : ADDR_W + 1;
      dw      = x16 ? 16 : 8;
      opb     = 2'b00;
      sub     = 2'b00;
      spec    = 1'b1;
      hasd    = 1'b0;
      is_read = 1'b0;
      is_prog = 1'b0;
      lim_sel = LIM_ONE;

      case (cmd)
         CMD_READ:      begin opb = 2'b10; spec = 1'b0; is_read = 1'b1; end
         CMD_WRITE:     begin opb = 2'b01; spec = 1'b0; hasd = 1'b1; is_prog = 1'b1; end
         CMD_ERASE:     begin opb = 2'b11; spec = 1'b0; is_prog = 1'b1; end
         CMD_ENABLE:    sub = 2'b11;
         CMD_ERASE_ALL: begin sub = 2'b10; is_prog = 1'b1; lim_sel = LIM_ERASE_ALL; end
         CMD_WRITE_ALL: begin sub = 2'b01; hasd = 1'b1; is_prog = 1'b1; lim_sel = LIM_WRITE_ALL; end
         default:       sub = 2'b00;
      endcase

      if (spec) begin
         af = FW'(sub) << (aw - 2);
      end else begin
         af = FW'(addr) & ((FW'(1) << aw) - FW'(1));
      end

      v   = FW'(1);
      v   = (v << 2) | FW'(opb);
      v   = (v << aw) | af;
      len = 3 + aw;
      if (hasd) begin
         v   = (v << dw) | (FW'(wdata) & ((FW'(1) << dw) - FW'(1)));
         len = len + dw;
      end

      frame   = v << (FW - len);
      n_cmd   = LW'(3 + aw);
      n_total = LW'(3 + aw + ((is_read || hasd) ? dw : 0));
   end

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
   import mw_host_pkg::*;
#(
   parameter int unsigned ADDR_W           = 8,
   parameter int unsigned HALF_CYC         = 63,
   parameter int unsigned CS_LOW_CYC       = 63,
   parameter int unsigned STAT_CYC         = 125,
   parameter int unsigned TO_ONE_CYC       = 2500000,
   parameter int unsigned TO_ERASE_ALL_CYC = 3750000,
   parameter int unsigned TO_WRITE_ALL_CYC = 7500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_cmd,
   input  logic [ADDR_W:0]   req_addr,
   input  logic [15:0]       req_wdata,
   input  logic              req_x16,
   output logic              rsp_valid,
   output logic [15:0]       rsp_rdata,
   output logic              rsp_timeout,
   output logic              mw_cs,
   output logic              mw_sk,
   output logic              mw_di,
   input  logic              mw_do
);
   localparam int unsigned FW   = ADDR_W + 20;
   localparam int unsigned LW   = $clog2(FW + 1);
   localparam int unsigned WMAX = (CS_LOW_CYC > STAT_CYC) ? CS_LOW_CYC : STAT_CYC;
   localparam int unsigned WW   = $clog2(WMAX + 1);
   localparam int unsigned CAP  = ((HALF_CYC > CS_LOW_CYC) ? HALF_CYC : CS_LOW_CYC) + 1;
   localparam int unsigned KW   = $clog2(CAP + 1);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (HALF_CYC < 1 || CS_LOW_CYC < 1 || STAT_CYC < 1) begin : g_bad_time
         $error("timing counts must be at least 1");
      end
      if (TO_ONE_CYC < 1 || TO_ERASE_ALL_CYC < 1 || TO_WRITE_ALL_CYC < 1) begin : g_bad_limit
         $error("poll limits must be at least 1");
      end
   endgenerate

   mw_state_e       state;
   logic [FW-1:0]   sr;
   logic [LW-1:0]   pulses;
   logic [LW-1:0]   n_cmd_q;
   logic [LW-1:0]   n_total_q;
   logic            rd_q;
   logic            prog_q;
   logic [1:0]      lim_q;
   logic [15:0]     rd_sr;
   logic [WW-1:0]   wcnt;
   logic            cs_q;
   logic            sk_q;
   logic            rv_q;
   logic            to_q;

   logic [FW-1:0]   fb_frame;
   logic [LW-1:0]   fb_n_cmd;
   logic [LW-1:0]   fb_n_total;
   logic            fb_read;
   logic            fb_prog;
   logic [1:0]      fb_lim;
   logic            tick;
   logic            frame_end;
   logic            expired;
   logic            poll_run;

   mw_frame_build #(
      .ADDR_W (ADDR_W),
      .FW     (FW),
      .LW     (LW)
   ) u_build (
      .cmd     (mw_cmd_e'(req_cmd)),
      .addr    (req_addr),
      .wdata   (req_wdata),
      .x16     (req_x16),
      .frame   (fb_frame),
      .n_cmd   (fb_n_cmd),
      .n_total (fb_n_total),
      .is_read (fb_read),
      .is_prog (fb_prog),
      .lim_sel (fb_lim)
   );

   mw_half_tick #(
      .HALF_CYC (HALF_CYC)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_SHIFT),
      .tick  (tick)
   );

   assign frame_end = (state == ST_SHIFT) && tick && !sk_q && (pulses == n_total_q);
   assign poll_run  = (state == ST_REST) || (state == ST_STAT) || (state == ST_POLL);

   mw_busy_timer #(
      .TO_ONE_CYC       (TO_ONE_CYC),
      .TO_ERASE_ALL_CYC (TO_ERASE_ALL_CYC),
      .TO_WRITE_ALL_CYC (TO_WRITE_ALL_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (frame_end),
      .run     (poll_run),
      .sel     (lim_q),
      .expired (expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sr        <= '0;
         pulses    <= '0;
         n_cmd_q   <= '0;
         n_total_q <= '0;
         rd_q      <= 1'b0;
         prog_q    <= 1'b0;
         lim_q     <= LIM_ONE;
         rd_sr     <= '0;
         wcnt      <= '0;
         cs_q      <= 1'b0;
         sk_q      <= 1'b0;
         rv_q      <= 1'b0;
         to_q      <= 1'b0;
      end else begin
         rv_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  sr        <= fb_frame;
                  n_cmd_q   <= fb_n_cmd;
                  n_total_q <= fb_n_total;
                  rd_q      <= fb_read;
                  prog_q    <= fb_prog;
                  lim_q     <= fb_lim;
                  pulses    <= '0;
                  rd_sr     <= '0;
                  cs_q      <= 1'b1;
                  sk_q      <= 1'b0;
                  state     <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sk_q) begin
                     if (rd_q && (pulses > n_cmd_q)) begin
                        rd_sr <= {rd_sr[14:0], mw_do};
                     end
                     if (pulses == n_total_q) begin
                        cs_q <= 1'b0;
                        wcnt <= WW'(CS_LOW_CYC - 1);
                        if (prog_q) begin
                           state <= ST_REST;
                        end else begin
                           rv_q  <= 1'b1;
                           to_q  <= 1'b0;
                           state <= ST_GAP;
                        end
                     end else begin
                        sk_q <= 1'b1;
                     end
                  end else begin
                     sk_q   <= 1'b0;
                     pulses <= pulses + 1'b1;
                     sr     <= sr << 1;
                  end
               end
            end
            ST_REST: begin
               if (wcnt == '0) begin
                  cs_q  <= 1'b1;
                  wcnt  <= WW'(STAT_CYC - 1);
                  state <= ST_STAT;
               end else begin
                  wcnt <= wcnt - 1'b1;
               end
            end
            ST_STAT: begin
               if (wcnt == '0) begin
                  state <= ST_POLL;
               end else begin
                  wcnt <= wcnt - 1'b1;
               end
            end
            ST_POLL: begin
               if (mw_do || expired) begin
                  cs_q  <= 1'b0;
                  rv_q  <= 1'b1;
                  to_q  <= !mw_do;
                  wcnt  <= WW'(CS_LOW_CYC - 1);
                  state <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (wcnt == '0) begin
                  state <= ST_IDLE;
               end else begin
                  wcnt <= wcnt - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (state == ST_IDLE);
   assign rsp_valid   = rv_q;
   assign rsp_timeout = to_q;
   assign rsp_rdata   = rd_sr;
   assign mw_cs       = cs_q;
   assign mw_sk       = sk_q;
   assign mw_di       = sr[FW-1];

   // Pin-level history used only by the properties below
   logic          sk_d;
   logic          cs_d;
   logic          di_d;
   logic [KW-1:0] sk_lvl;
   logic [KW-1:0] cs_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sk_d   <= 1'b0;
         cs_d   <= 1'b0;
         di_d   <= 1'b0;
         sk_lvl <= KW'(CAP);
         cs_lo  <= KW'(CAP);
      end else begin
         sk_d <= mw_sk;
         cs_d <= mw_cs;
         di_d <= mw_di;
         if (mw_sk != sk_d) begin
            sk_lvl <= KW'(1);
         end else if (sk_lvl != KW'(CAP)) begin
            sk_lvl <= sk_lvl + 1'b1;
         end
         if (mw_cs) begin
            cs_lo <= '0;
         end else if (cs_lo != KW'(CAP)) begin
            cs_lo <= cs_lo + 1'b1;
         end
      end
   end

   // R4
   sk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_sk != sk_d) |-> (sk_lvl >= KW'(HALF_CYC)));

   // R4
   di_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_sk |-> (mw_di == di_d));

   // R5
   sk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mw_cs |-> !mw_sk);

   // R6
   cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_cs && !cs_d) |-> (cs_lo >= KW'(CS_LOW_CYC)));

   // R11
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_cs |-> !req_ready);

   // R11
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: tb/test_mw_eeprom_host.sv
module test_mw_eeprom_host;
   localparam int AW  = 8;
   localparam int H   = 3;
   localparam int CL  = 4;
   localparam int ST  = 5;
   localparam int TL1 = 200;
   localparam int TL2 = 300;
   localparam int TL3 = 400;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [2:0]  req_cmd;
   logic [AW:0] req_addr;
   logic [15:0] req_wdata;
   logic        req_x16;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        rsp_timeout;
   logic        mw_cs;
   logic        mw_sk;
   logic        mw_di;
   logic        mw_do;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mw_eeprom_host #(
      .ADDR_W           (AW),
      .HALF_CYC         (H),
      .CS_LOW_CYC       (CL),
      .STAT_CYC         (ST),
      .TO_ONE_CYC       (TL1),
      .TO_ERASE_ALL_CYC (TL2),
      .TO_WRITE_ALL_CYC (TL3)
   ) i_mw_eeprom_host (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_cmd     (req_cmd),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .req_x16     (req_x16),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .rsp_timeout (rsp_timeout),
      .mw_cs       (mw_cs),
      .mw_sk       (mw_sk),
      .mw_di       (mw_di),
      .mw_do       (mw_do)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behaviour of the memory's data line, per cycle after acceptance
   function automatic bit do_model(int k, bit rd, bit prog, int c, int n, int f,
                                   int busy, int wd, int dw);
      int p;
      if (k < f) begin
         if (!rd || k < H) return 1'b1;
         p = (k - H) / (2 * H);
         if (p == c - 1) return 1'b0;
         if (p >= c && p < n) return 1'((wd >> (dw - 1 - (p - c))) & 1);
         return 1'b1;
      end
      if (prog) return (k >= f + busy);
      return 1'b1;
   endfunction

   task automatic run_cmd(input int cmd, input int addr, input int wd, input bit x16,
                          input int busy);
      int aw, dw, c, n, f, r, lim, len, rises, p;
      bit rd, prog, hasd, exp_to, sk_prev;
      bit ecs, esk, edi, erv, erdy;
      logic [1:0] opb, sub;
      bit bits[$];
      string cs_tag, rv_tag;

      aw   = x16 ? AW : AW + 1;
      dw   = x16 ? 16 : 8;
      rd   = (cmd == 0);
      prog = (cmd == 1 || cmd == 2 || cmd == 5 || cmd == 6);
      hasd = (cmd == 1 || cmd == 6);
      c    = 3 + aw;
      n    = c + ((rd || hasd) ? dw : 0);
      f    = (2 * n + 1) * H;
      lim  = (cmd == 5) ? TL2 : (cmd == 6) ? TL3 : TL1;

      case (cmd)
         0:       opb = 2'b10;
         1:       opb = 2'b01;
         2:       opb = 2'b11;
         default: opb = 2'b00;
      endcase
      case (cmd)
         3:       sub = 2'b11;
         5:       sub = 2'b10;
         6:       sub = 2'b01;
         default: sub = 2'b00;
      endcase
      bits.push_back(1'b1);
      bits.push_back(opb[1]);
      bits.push_back(opb[0]);
      if (cmd <= 2) begin
         for (int i = aw - 1; i >= 0; i--) bits.push_back(1'((addr >> i) & 1));
      end else begin
         bits.push_back(sub[1]);
         bits.push_back(sub[0]);
         for (int i = 0; i < aw - 2; i++) bits.push_back(1'b0);
      end
      if (hasd) begin
         for (int i = dw - 1; i >= 0; i--) bits.push_back(1'((wd >> i) & 1));
      end

      if (prog) begin
         r = -1;
         for (int e = f + CL + ST + 1; r < 0; e++) begin
            if (do_model(e - 1, rd, prog, c, n, f, busy, wd, dw) || (e - 1 - f) >= lim) r = e;
         end
         exp_to = !do_model(r - 1, rd, prog, c, n, f, busy, wd, dw);
      end else begin
         r      = f;
         exp_to = 1'b0;
      end
      len    = r + CL + 1;
      rv_tag = prog ? "R8" : "R10";

      @(negedge clk);
      req_cmd   = 3'(cmd);
      req_addr  = (AW + 1)'(addr);
      req_wdata = 16'(wd);
      req_x16   = x16;
      req_valid = 1'b1;
      check(req_ready == 1'b1, "R11 ready before request", int'(req_ready), 1);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      mw_do     = do_model(0, rd, prog, c, n, f, busy, wd, dw);
      rises     = 0;
      sk_prev   = 1'b0;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         if (k < f) begin
            ecs  = 1'b1;
            esk  = (k >= H) && (((k - H) / H) % 2 == 0);
            p    = k / (2 * H);
            edi  = (p < bits.size()) ? bits[p] : 1'b0;
            erv  = 1'b0;
            erdy = 1'b0;
         end else begin
            ecs  = prog && (k >= f + CL) && (k < r);
            esk  = 1'b0;
            edi  = 1'b0;
            erv  = (k == r);
            erdy = (k >= r + CL);
         end
         cs_tag = (k < H) ? "R5 cs setup" : "R6 cs level";
         check(mw_cs == ecs, cs_tag, int'(mw_cs), int'(ecs));
         check(mw_sk == esk, "R4 sk level", int'(mw_sk), int'(esk));
         check(mw_di == edi, "R2 di bit", int'(mw_di), int'(edi));
         check(rsp_valid == erv, rv_tag, int'(rsp_valid), int'(erv));
         check(req_ready == erdy, "R11 ready level", int'(req_ready), int'(erdy));
         if (mw_sk && !sk_prev) rises++;
         sk_prev = mw_sk;
         if (k == r) begin
            check(rsp_rdata == (rd ? 16'(wd & ((1 << dw) - 1)) : 16'h0), "R7 read data",
                  int'(rsp_rdata), rd ? (wd & ((1 << dw) - 1)) : 0);
            check(rsp_timeout == exp_to, "R9 timeout flag", int'(rsp_timeout), int'(exp_to));
         end
         @(posedge clk);
         #1;
         mw_do = do_model(k + 1, rd, prog, c, n, f, busy, wd, dw);
      end
      check(rises == n, "R3 pulse count", rises, n);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_cmd   = '0;
      req_addr  = '0;
      req_wdata = '0;
      req_x16   = 1'b1;
      mw_do     = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(mw_cs == 1'b0 && mw_sk == 1'b0 && mw_di == 1'b0, "R1 pins in reset",
            int'({mw_cs, mw_sk, mw_di}), 0);
      check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake in reset",
            int'({req_ready, rsp_valid}), 2);
      rst_n = 1'b1;
      @(negedge clk);
      check(mw_cs == 1'b0 && req_ready == 1'b1 && rsp_valid == 1'b0, "R1 after release",
            int'({mw_cs, req_ready, rsp_valid}), 2);

      run_cmd(3, 0, 0, 1'b1, 0);              // R10 enable, 16-bit
      run_cmd(0, 'hA5, 'hC3A6, 1'b1, 0);      // R7 read, 16-bit
      run_cmd(0, 'h1C3, 'h5B, 1'b0, 0);       // R7 read, 8-bit, 20 pulses
      run_cmd(3, 0, 0, 1'b0, 0);              // R3 enable, 8-bit, 12 pulses
      run_cmd(1, 'h3C, 'hBEEF, 1'b1, 0);      // R8 ready at first poll
      run_cmd(1, 'h155, 'h96, 1'b0, 40);      // R8 busy then ready
      run_cmd(2, 'h11, 0, 1'b1, 60);          // R8 erase
      run_cmd(5, 0, 0, 1'b1, 10);             // R8 erase-all
      run_cmd(6, 0, 'h1234, 1'b1, 30);        // R8 write-all
      run_cmd(1, 'h07, 'h0F0F, 1'b1, 100000); // R9 single limit
      run_cmd(5, 0, 0, 1'b0, 100000);         // R9 erase-all limit
      run_cmd(6, 0, 'h7E, 1'b0, 100000);      // R9 write-all limit
      run_cmd(4, 'h1FF, 0, 1'b1, 0);          // R2 disable
      run_cmd(7, 'h0AA, 0, 1'b0, 0);          // R2 code 7 as disable

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule